// File: doc/BRIEF.md
# Horizontal/Vertical Sync Tracker with Dual-Pixel Lane Splitter

This block takes the horizontal and vertical sync lines delivered by a link receiver and regenerates them. Each line is normalised to active-high by an optional per-line inversion. Its period and high width are then measured from one rising edge to the next. Once the same timing has been seen for three periods in a row, the channel locks. From then on a free-running phase counter predicts the level of every sample, and a two-of-three vote decides whether the prediction or the received sample goes to the output. An isolated bit error on a sync line therefore never reaches the output, while a real change in timing comes through after two samples. If three periods in a row disagree with the tracked timing, the channel reports a one-cycle lost pulse, unlocks and starts tracking again from scratch.

Each transfer carries up to two sync samples per line. When the far end sends two pixels per transfer, the local output is single-rate and sync encoding is on, the block runs in split mode. In that mode bit 0 of each line is the first pixel's sample and bit 1 is the second's. Both samples pass through the tracker in that order within one cycle, and the result of the first goes to output lane 0 and the result of the second to lane 1. In every other mode only bit 0 is used, and lane 1 stays low. A tracked period only counts towards lock if it obeys the pulse-width rules of the selected rate.

Top module: `hvsync_tracker`

## Requirements
- R1: When `cfg_inv_hs` (or `cfg_inv_vs`) is 1, the received HS (or VS) bits are inverted before any processing. All outputs are active-high, so an inverted input with inversion enabled gives the same outputs as the plain input without inversion.
- R2: While a channel is unlocked, each lane carries the normalised sample of the transfer accepted at the previous clock edge. `sync_vld` is 1 in the cycle after an accepted transfer and 0 otherwise. In cycles with no transfer the lanes keep their values and the lost flags are 0.
- R3: Period is the number of samples from one rising edge to the next, and high width is the number of samples from a rising edge to the following falling edge. The first rising edge after reset only arms the measurement. A channel locks on the rising edge that completes three consecutive valid periods with equal period and equal high width. The lock flag is 1 in the cycle after that transfer.
- R4: In single-rate rule mode (`cfg_far_dbl`=0), a period whose low part is shorter than 2 samples is invalid. It clears the run of equal periods, so such a waveform never locks.
- R5: In double-rate rule mode (`cfg_far_dbl`=1), a period is valid only if its low part is at least 5 samples, its high part at least 2 samples and its total length even.
- R6: While locked, a single received sample that disagrees with the predicted level is replaced by the prediction on the output.
- R7: While locked, if the current sample and at least one of the two samples before it disagree with the prediction, the received sample is output.
- R8: While locked, three consecutive periods that differ from the tracked period or high width produce a one-cycle lost pulse. The pulse comes in the same cycle that the lock flag drops. A later relock needs three fresh equal periods counted after the lost edge.
- R9: Split mode (`cfg_far_dbl`=1, `cfg_near_dbl`=0, `cfg_enc_en`=1): in each line, bit 0 is the earlier sample and bit 1 the later one. Both are tracked in that order, and they appear on lane 0 and lane 1 respectively.
- R10: Outside split mode, bit 1 of each input line is ignored and lane 1 (bit 1 of `sync_hs`/`sync_vs`) stays 0.
- R11: HS and VS are tracked independently, each with its own lock and lost flags.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_inv_hs | input | 1 | Invert received HS bits |
| cfg_inv_vs | input | 1 | Invert received VS bits |
| cfg_far_dbl | input | 1 | Far end sends two pixels per transfer; selects double-rate pulse rules |
| cfg_near_dbl | input | 1 | Local output is double-rate |
| cfg_enc_en | input | 1 | Sync encoding enabled on the link |
| link_hs | input | 2 | Received HS samples; bit 0 earlier, bit 1 later |
| link_vs | input | 2 | Received VS samples; bit 0 earlier, bit 1 later |
| link_vld | input | 1 | A transfer is present this cycle |
| sync_hs | output | 2 | Regenerated HS, lane 0 and lane 1 |
| sync_vs | output | 2 | Regenerated VS, lane 0 and lane 1 |
| sync_vld | output | 1 | Outputs updated from a transfer |
| hs_locked | output | 1 | HS timing locked |
| vs_locked | output | 1 | VS timing locked |
| hs_lost | output | 1 | One-cycle pulse: HS lock lost |
| vs_lost | output | 1 | One-cycle pulse: VS lock lost |

## Verification
The bench sweeps every period from 3 to 9 against every high width in single-rate mode. This separates waveforms that lock on the fourth rising edge from those whose low pulse is too short. A list of double-rate shapes then tests the low, high and evenness rules one at a time. On a locked waveform the bench first inverts a single sample at every phase of the period, then inverts two adjacent samples. This tells the suppression of single errors apart from the two-of-three pass-through. A period change shows the lost pulse and the fresh relock, and an interleaved two-sample run with a glitch in the later sample checks lane order in split mode.

// File: rtl/sync_trk_pkg.sv
package sync_trk_pkg;

    localparam int CNT_W         = 10;
    localparam int LANES         = 2;
    localparam int NCH           = 2;
    localparam int LOCK_RUN      = 3;
    localparam int MISS_RUN      = 3;
    localparam int LOW_MIN_ONE   = 2;
    localparam int LOW_MIN_DBL   = 5;
    localparam int HIGH_MIN_DBL  = 2;
    localparam int RUN_W         = $clog2(LOCK_RUN + 1);
    localparam int MISS_W        = $clog2(MISS_RUN + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        LM_SINGLE = 1'b0,
        LM_SPLIT  = 1'b1
    } lane_mode_e;

    // per-channel tracking state
    typedef struct packed {
        logic              lvl;      // previous normalised sample
        logic              armed;    // a rising edge has been seen
        cnt_t              cnt;      // samples since last rising edge
        cnt_t              hi;       // high width of current period
        cnt_t              per_ref;  // tracked period
        cnt_t              hi_ref;   // tracked high width
        logic [RUN_W-1:0]  eq;       // run of equal periods
        logic [MISS_W-1:0] miss;     // run of mismatching periods
        logic              locked;
        cnt_t              phase;    // predicted phase of next sample
        logic [1:0]        dis;      // disagreement history
    } trk_t;

    typedef struct packed {
        trk_t st;
        logic y;
        logic lost;
    } step_t;

    // conditioned transfer
    typedef struct packed {
        logic [LANES-1:0] hs;
        logic [LANES-1:0] vs;
        logic [LANES-1:0] take;
        logic             dbl_rule;
        logic             vld;
    } cond_t;

    function automatic logic [LANES-1:0] lane_take(lane_mode_e m);
        return (m == LM_SPLIT) ? {LANES{1'b1}} : LANES'(1);
    endfunction

    function automatic logic rule_ok(cnt_t per, cnt_t hi, logic dbl);
        cnt_t low;
        if (hi == '0 || per <= hi) return 1'b0;
        low = per - hi;
        if (dbl)
            return (low >= cnt_t'(LOW_MIN_DBL)) && (hi >= cnt_t'(HIGH_MIN_DBL)) && !per[0];
        return low >= cnt_t'(LOW_MIN_ONE);
    endfunction

    // one sample through the tracker and voter
    function automatic step_t trk_step(trk_t s, logic x, logic dbl);
        step_t      r;
        trk_t       n;
        logic       rise;
        logic       fall;
        logic       pred;
        logic       d;
        logic       match;
        logic [1:0] votes;
        n      = s;
        r.lost = 1'b0;
        rise   = x & ~s.lvl;
        fall   = ~x & s.lvl;
        pred   = s.phase < s.hi_ref;
        d      = x ^ pred;

        if (s.locked) begin
            votes   = {1'b0, d} + {1'b0, s.dis[0]} + {1'b0, s.dis[1]};
            r.y     = (votes >= 2'd2) ? x : pred;
            n.dis   = {s.dis[0], d};
            n.phase = (s.phase + 1'b1 >= s.per_ref) ? '0 : s.phase + 1'b1;
        end else begin
            r.y   = x;
            n.dis = '0;
        end

        n.lvl = x;
        if (rise)
            n.cnt = cnt_t'(1);
        else if (s.cnt != '1)
            n.cnt = s.cnt + 1'b1;
        if (fall)
            n.hi = s.cnt;

        if (rise) begin
            n.armed = 1'b1;
            if (s.armed) begin
                match = (s.cnt == s.per_ref) && (s.hi == s.hi_ref);
                if (s.locked) begin
                    if (match) begin
                        n.miss = '0;
                    end else if (int'(s.miss) + 1 >= MISS_RUN) begin
                        n.locked = 1'b0;
                        n.miss   = '0;
                        n.eq     = '0;
                        n.dis    = '0;
                        r.lost   = 1'b1;
                    end else begin
                        n.miss = s.miss + 1'b1;
                    end
                end else if (!rule_ok(s.cnt, s.hi, dbl)) begin
                    n.eq = '0;
                end else if (match && s.eq != '0) begin
                    if (int'(s.eq) + 1 >= LOCK_RUN) begin
                        n.locked = 1'b1;
                        n.phase  = cnt_t'(1);
                        n.miss   = '0;
                        n.dis    = '0;
                        n.eq     = '0;
                    end else begin
                        n.eq = s.eq + 1'b1;
                    end
                end else begin
                    n.per_ref = s.cnt;
                    n.hi_ref  = s.hi;
                    n.eq      = RUN_W'(1);
                end
            end
        end
        r.st = n;
        return r;
    endfunction

endpackage

// File: rtl/sync_trk_cond.sv
module sync_trk_cond
    import sync_trk_pkg::*;
(
    input  logic             inv_hs,
    input  logic             inv_vs,
    input  logic             far_dbl,
    input  logic             near_dbl,
    input  logic             enc_en,
    input  logic [LANES-1:0] hs_raw,
    input  logic [LANES-1:0] vs_raw,
    input  logic             vld,
    output cond_t            cnd
);
    lane_mode_e mode;

    always_comb begin
        mode         = (far_dbl && !near_dbl && enc_en) ? LM_SPLIT : LM_SINGLE;
        cnd.hs       = hs_raw ^ {LANES{inv_hs}};
        cnd.vs       = vs_raw ^ {LANES{inv_vs}};
        cnd.take     = lane_take(mode);
        cnd.dbl_rule = far_dbl;
        cnd.vld      = vld;
    end
endmodule

// File: rtl/sync_trk_chan.sv
module sync_trk_chan
    import sync_trk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] smp,
    input  logic [LANES-1:0] take,
    input  logic             dbl,
    input  logic             vld,
    output logic [LANES-1:0] y,
    output logic             lost,
    output logic             locked
);
    trk_t             state;
    trk_t             chain [LANES+1];
    step_t            res   [LANES];
    logic [LANES-1:0] lost_v;

    assign chain[0] = state;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign res[i]       = trk_step(chain[i], smp[i], dbl);
        assign chain[i + 1] = take[i] ? res[i].st : chain[i];
        assign y[i]         = take[i] & res[i].y;
        assign lost_v[i]    = take[i] & res[i].lost;
    end

    assign lost   = |lost_v;
    assign locked = state.locked;

    always_ff @(posedge clk) begin
        if (rst)
            state <= '0;
        else if (vld)
            state <= chain[LANES];
    end
endmodule

// File: rtl/sync_trk_out.sv
module sync_trk_out
    import sync_trk_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       vld,
    input  logic [NCH-1:0][LANES-1:0]  y_in,
    input  logic [NCH-1:0]             lost_in,
    output logic [NCH-1:0][LANES-1:0]  y_q,
    output logic [NCH-1:0]             lost_q,
    output logic                       vld_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            y_q    <= '0;
            lost_q <= '0;
            vld_q  <= 1'b0;
        end else if (vld) begin
            y_q    <= y_in;
            lost_q <= lost_in;
            vld_q  <= 1'b1;
        end else begin
            lost_q <= '0;
            vld_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/hvsync_tracker.sv
module hvsync_tracker
    import sync_trk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_inv_hs,
    input  logic       cfg_inv_vs,
    input  logic       cfg_far_dbl,
    input  logic       cfg_near_dbl,
    input  logic       cfg_enc_en,
    input  logic [1:0] link_hs,
    input  logic [1:0] link_vs,
    input  logic       link_vld,
    output logic [1:0] sync_hs,
    output logic [1:0] sync_vs,
    output logic       sync_vld,
    output logic       hs_locked,
    output logic       vs_locked,
    output logic       hs_lost,
    output logic       vs_lost
);
    cond_t                      cnd;
    logic [NCH-1:0][LANES-1:0]  ch_smp;
    logic [NCH-1:0][LANES-1:0]  ch_y;
    logic [NCH-1:0][LANES-1:0]  ch_yq;
    logic [NCH-1:0]             ch_lost;
    logic [NCH-1:0]             ch_lostq;
    logic [NCH-1:0]             ch_locked;

    sync_trk_cond u_cond (
        .inv_hs   (cfg_inv_hs),
        .inv_vs   (cfg_inv_vs),
        .far_dbl  (cfg_far_dbl),
        .near_dbl (cfg_near_dbl),
        .enc_en   (cfg_enc_en),
        .hs_raw   (link_hs),
        .vs_raw   (link_vs),
        .vld      (link_vld),
        .cnd      (cnd)
    );

    assign ch_smp[0] = cnd.hs;
    assign ch_smp[1] = cnd.vs;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sync_trk_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .smp    (ch_smp[c]),
            .take   (cnd.take),
            .dbl    (cnd.dbl_rule),
            .vld    (cnd.vld),
            .y      (ch_y[c]),
            .lost   (ch_lost[c]),
            .locked (ch_locked[c])
        );
    end

    sync_trk_out u_out (
        .clk     (clk),
        .rst     (rst),
        .vld     (cnd.vld),
        .y_in    (ch_y),
        .lost_in (ch_lost),
        .y_q     (ch_yq),
        .lost_q  (ch_lostq),
        .vld_q   (sync_vld)
    );

    assign sync_hs   = ch_yq[0];
    assign sync_vs   = ch_yq[1];
    assign hs_lost   = ch_lostq[0];
    assign vs_lost   = ch_lostq[1];
    assign hs_locked = ch_locked[0];
    assign vs_locked = ch_locked[1];
endmodule

// File: rtl/hvsync_tracker_chk.sv
module hvsync_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_far_dbl,
    input logic       cfg_near_dbl,
    input logic       cfg_enc_en,
    input logic       link_vld,
    input logic [1:0] sync_hs,
    input logic [1:0] sync_vs,
    input logic       sync_vld,
    input logic       hs_locked,
    input logic       vs_locked,
    input logic       hs_lost,
    input logic       vs_lost
);
    p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
        link_vld |=> sync_vld);

    p_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !link_vld |=> !sync_vld);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !link_vld |=> ($stable(sync_hs) && $stable(sync_vs) && !hs_lost && !vs_lost));

    p_lane1_low_r10: assert property (@(posedge clk) disable iff (rst)
        !(cfg_far_dbl && !cfg_near_dbl && cfg_enc_en) |-> (!sync_hs[1] && !sync_vs[1]));

    p_hs_lost_drop_r8: assert property (@(posedge clk) disable iff (rst)
        hs_lost |-> (!hs_locked && $past(hs_locked)));

    p_vs_lost_drop_r8: assert property (@(posedge clk) disable iff (rst)
        vs_lost |-> (!vs_locked && $past(vs_locked)));

    p_hs_fall_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_locked) |-> hs_lost);

    p_vs_fall_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(vs_locked) |-> vs_lost);
endmodule

bind hvsync_tracker hvsync_tracker_chk u_chk (.*);

// File: tb/hvsync_tracker_bench.sv
module hvsync_tracker_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_inv_hs = 1'b0, cfg_inv_vs = 1'b0;
    logic       cfg_far_dbl = 1'b0, cfg_near_dbl = 1'b0, cfg_enc_en = 1'b0;
    logic [1:0] link_hs = '0, link_vs = '0;
    logic       link_vld = 1'b0;
    logic [1:0] sync_hs, sync_vs;
    logic       sync_vld, hs_locked, vs_locked, hs_lost, vs_lost;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hvsync_tracker u_hvsync_tracker (
        .clk(clk), .rst(rst),
        .cfg_inv_hs(cfg_inv_hs), .cfg_inv_vs(cfg_inv_vs),
        .cfg_far_dbl(cfg_far_dbl), .cfg_near_dbl(cfg_near_dbl), .cfg_enc_en(cfg_enc_en),
        .link_hs(link_hs), .link_vs(link_vs), .link_vld(link_vld),
        .sync_hs(sync_hs), .sync_vs(sync_vs), .sync_vld(sync_vld),
        .hs_locked(hs_locked), .vs_locked(vs_locked),
        .hs_lost(hs_lost), .vs_lost(vs_lost)
    );

    task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic wv(int k, int p, int h);
        return (k % p) < h;
    endfunction

    task automatic do_reset(logic ih, logic iv, logic fd, logic nd, logic en);
        @(negedge clk);
        rst = 1'b1; link_vld = 1'b0; link_hs = '0; link_vs = '0;
        cfg_inv_hs = ih; cfg_inv_vs = iv;
        cfg_far_dbl = fd; cfg_near_dbl = nd; cfg_enc_en = en;
        repeat (3) @(negedge clk);
        chk("R12", "reset hs", sync_hs, 2'b00);
        chk("R12", "reset vs", sync_vs, 2'b00);
        chk("R12", "reset flags", {hs_locked | vs_locked, hs_lost | vs_lost | sync_vld}, 2'b00);
        rst = 1'b0;
    endtask

    task automatic xfer(logic [1:0] h, logic [1:0] v);
        link_hs = h; link_vs = v; link_vld = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(logic [1:0] h, logic [1:0] v);
        link_hs = h; link_vs = v; link_vld = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R3/R4/R2/R10: single-rate sweep of period and high width
        for (int p = 3; p <= 9; p++) begin
            for (int h = 1; h < p; h++) begin
                do_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
                for (int k = 0; k < 4 * p + 3; k++) begin
                    logic b;
                    logic el;
                    b  = wv(k, p, h);
                    el = (p - h >= 2) && (k >= 3 * p);
                    xfer({~b, b}, 2'b10);
                    chk("R2", "vld", {1'b0, sync_vld}, 2'b01);
                    chk("R2", "hs lane0", {1'b0, sync_hs[0]}, {1'b0, b});
                    chk("R10", "lane1 low", {sync_hs[1], sync_vs[1]}, 2'b00);
                    chk((p - h >= 2) ? "R3" : "R4", "hs locked", {1'b0, hs_locked}, {1'b0, el});
                    chk("R11", "vs idle", {vs_locked, sync_vs[0]}, 2'b00);
                end
            end
        end

        // R5: double-rate pulse rules
        begin
            int pp [6] = '{8, 7, 8, 8, 10, 6};
            int hh [6] = '{3, 2, 4, 1, 2, 1};
            logic ok [6] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
            for (int c = 0; c < 6; c++) begin
                do_reset(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
                for (int k = 0; k < 4 * pp[c] + 2; k++) begin
                    logic b;
                    b = wv(k, pp[c], hh[c]);
                    xfer({1'b1, b}, 2'b00);
                    chk("R5", "dbl lock", {1'b0, hs_locked},
                        {1'b0, ok[c] && (k >= 3 * pp[c])});
                    chk("R10", "lane1 low dbl", {1'b0, sync_hs[1]}, 2'b00);
                end
            end
        end

        // R6: single wrong sample at every phase of a locked period
        for (int j = 0; j < 6; j++) begin
            do_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            for (int k = 0; k < 55; k++) begin
                logic b;
                b = wv(k, 6, 2);
                xfer({1'b0, (k == 30 + j) ? ~b : b}, 2'b00);
                chk("R6", "glitch filtered", {1'b0, sync_hs[0]}, {1'b0, b});
                chk("R6", "lock kept", {hs_locked, hs_lost}, {k >= 18, 1'b0});
            end
        end

        // R7: two adjacent wrong samples, second one passes
        do_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 70; k++) begin
            logic b;
            logic g;
            b = wv(k, 10, 3);
            g = (k == 45 || k == 46) ? 1'b1 : b;
            xfer({1'b0, g}, 2'b00);
            chk("R7", "vote", {1'b0, sync_hs[0]}, {1'b0, (k == 46) ? 1'b1 : b});
            chk("R7", "lock kept", {hs_locked, hs_lost}, {k >= 30, 1'b0});
        end

        // R8: period change loses lock, then relocks
        do_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 100; k++) begin
            logic b;
            b = (k < 36) ? wv(k, 6, 2) : wv(k - 36, 8, 2);
            xfer({1'b0, b}, 2'b00);
            chk("R8", "locked", {1'b0, hs_locked},
                {1'b0, ((k >= 18) && (k < 60)) || (k >= 84)});
            chk("R8", "lost pulse", {1'b0, hs_lost}, {1'b0, k == 60});
            if (k < 36 || k > 60)
                chk("R8", "data", {1'b0, sync_hs[0]}, {1'b0, b});
        end

        // R1/R11/R2: inversion, independent channels, idle cycles hold
        do_reset(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 45; k++) begin
            logic bh;
            logic bv;
            bh = wv(k, 6, 2);
            bv = wv(k, 9, 3);
            xfer({1'b1, ~bh}, {1'b0, bv});
            chk("R1", "inverted hs", {1'b0, sync_hs[0]}, {1'b0, bh});
            chk("R11", "vs data", {1'b0, sync_vs[0]}, {1'b0, bv});
            chk("R11", "locks", {hs_locked, vs_locked}, {k >= 18, k >= 27});
            if (k % 7 == 6) begin
                idle({~bh, bh}, {~bv, ~bv});
                chk("R2", "idle vld", {1'b0, sync_vld}, 2'b00);
                chk("R2", "idle hold", {sync_hs[0], sync_vs[0]}, {bh, bv});
                chk("R2", "idle lost", {hs_lost, vs_lost}, 2'b00);
            end
        end

        // R9: split mode, lane order and glitch on later sample
        do_reset(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        for (int t = 0; t < 40; t++) begin
            logic h0, h1, v0, v1;
            h0 = wv(2 * t, 8, 3);
            h1 = wv(2 * t + 1, 8, 3);
            v0 = wv(2 * t, 10, 4);
            v1 = wv(2 * t + 1, 10, 4);
            xfer({(t == 20) ? ~h1 : h1, h0}, {v1, v0});
            chk("R9", "hs lanes", sync_hs, {h1, h0});
            chk("R9", "vs lanes", sync_vs, {v1, v0});
            chk("R9", "locks", {hs_locked, vs_locked}, {t >= 12, t >= 15});
            chk("R9", "no lost", {hs_lost, vs_lost}, 2'b00);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule